// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Register Window

This block is an asynchronous serial transmitter and receiver for a peripheral gate array. A microprocessor reaches it through an eight-byte register window. Each access is qualified by an active-low chip enable and an address offset on three bits. It has separate active-low read and write strobes and an 8-bit bidirectional data bus. Software sets the line format at run time: 7 or 8 data bits, no parity or even or odd parity, and 1 or 2 stop bits. It also picks one of eight bit rates, enables the transmitter and the receiver separately, and chooses where the transmit line goes. The line goes either to the RS232C pin or to a tape output, and the tape output has its own polarity invert.

The transmitter has one holding register in front of its shift register, so a new byte can be written while the previous one is still shifting out. The receiver oversamples the line at 16 ticks per bit. It confirms a start bit at the half-bit point and then samples every later bit at its middle. Parity, overrun and framing errors each set their own sticky flag. Reading the status register clears those flags. Reading the receive data register clears the received-byte flag. An active-low interrupt request reports a waiting byte, or an enabled transmitter that can take more data.

Top module: `sio_window`

## Requirements
- R1: After reset, TXD is at mark (1) and the interrupt request is high. Status (offset 3'b011) reads 8'h01, meaning only the transmitter-ready bit 0 is set. Mode (offset 3'b100) reads 8'h00.
- R2: The mode register at offset 3'b100 keeps bits 7 (transmit enable), 6 (receive enable), 4 (tape path) and 2..0 (rate code), and reads 0 in bits 5 and 3. The auxiliary register at offset 3'b101 keeps only bit 4 (tape invert).
- R3: A read at offset 3'b110 returns bit 2 = NOT cts_n, bit 3 = NOT dsr_n, bit 4 = NOT dcd_n and bit 7 = strap, with 0 in every other bit.
- R4: A byte written to offset 3'b010 is sent as a start bit (0), then the data bits least significant first, then the stop bits (1). Each bit lasts 16 rate ticks, and one rate tick is BASE_DIV x 2^code clock cycles.
- R5: A write at offset 3'b011 sets the format: bit 2 = 8 data bits (0 = 7), bit 4 = parity on, bit 5 = even (0 = odd), bit 7 = two stop bits. With parity on, the parity bit follows the data and gives the chosen parity over the data bits.
- R6: A byte written while transmit enable is 0 stays held: status bit 0 reads 0 and TXD stays at mark. The byte is sent once transmit enable is set.
- R7: A received frame puts its byte at offset 3'b010 and sets status bit 1. Reading offset 3'b010 clears bit 1. In 7-bit mode, bit 7 of the byte reads 0.
- R8: A parity mismatch sets status bit 3, and a 0 sampled in the first stop bit sets status bit 5. A read of the status register clears both.
- R9: A frame that completes while status bit 1 is still set raises status bit 4 and is discarded; the earlier byte is kept.
- R10: A low pulse on RXD that is gone by the half-bit sample is ignored, and no byte is received.
- R11: irq_n is low while status bit 1 is set, or while status bit 0 and transmit enable are both set. Otherwise irq_n is high.
- R12: With mode bit 4 set, the serial bits go to tape_out and TXD is held at mark. tape_out is inverted while auxiliary bit 4 is set.
- R13: A write strobe with cs_n high changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip enable for the register window |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register offset |
| data | inout | 8 | Bidirectional data bus, driven by the block only during a qualified read |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| strap | input | 1 | Board configuration strap, read back in bit 7 of offset 3'b110 |
| txd | output | 1 | RS232C transmit line |
| tape_out | output | 1 | Tape-path transmit signal |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker watches on every cycle that TXD stays at mark while the tape path is selected, and that a waiting byte always pulls the interrupt low. It also checks that a frame arriving on a full receiver raises the overrun flag, that reading the data register drops the received flag, and that a transmit frame starts only when the transmitter is enabled. Only the bench scenarios can show the serial behaviour over a whole frame: bit order, parity value, stop-bit count, bit length and glitch rejection. The same goes for the side effects of a read that show up in later reads, and the register readback values.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int FRAME_W = 12;
   localparam int SAMP_W  = 16;

   localparam logic [2:0] OFF_DATA  = 3'b010;
   localparam logic [2:0] OFF_STAT  = 3'b011;
   localparam logic [2:0] OFF_MODE  = 3'b100;
   localparam logic [2:0] OFF_AUX   = 3'b101;
   localparam logic [2:0] OFF_MODEM = 3'b110;

   typedef struct packed {
      logic stop2;
      logic par_even;
      logic par_en;
      logic data8;
   } sio_fmt_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

   // parity bit value that gives the requested parity over the data bits
   function automatic logic par_bit(input logic [7:0] d, input logic data8, input logic even);
      logic p;
      p = ^(data8 ? d : {1'b0, d[6:0]});
      return even ? p : ~p;
   endfunction
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("sio_sync: STAGES must be at least 1");
      end
      if (STAGES <= 1) begin : g_single
         logic r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= 1'b1;
            else        r <= d;
         assign q = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '1;
            else        r <= {r[STAGES-2:0], d};
         assign q = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
   parameter int BASE_DIV = 4,
   parameter int CODE_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int MAX_DIV = BASE_DIV * (1 << ((1 << CODE_W) - 1));
   localparam int CW      = $clog2(MAX_DIV + 1);

   generate
      if (BASE_DIV < 1) begin : g_bad_div
         $error("sio_baud: BASE_DIV must be at least 1");
      end
      if (CODE_W < 1 || CODE_W > 3) begin : g_bad_code
         $error("sio_baud: CODE_W must be 1..3");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   assign lim  = CW'(BASE_DIV) << code;
   assign tick = (cnt >= lim - CW'(1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  sio_fmt_t   fmt,
   input  logic       tx_en,
   input  logic       load,
   input  logic [7:0] load_data,
   output logic       ready,
   output logic       busy,
   output logic       line
);
   logic                hold_full;
   logic [7:0]          hold_data;
   logic [FRAME_W-1:0]  frame;
   logic [FRAME_W-1:0]  sh;
   logic [3:0]          nbits;
   logic [3:0]          left;
   logic [3:0]          tcnt;
   logic                start;

   assign start = hold_full && !busy && tx_en;
   assign ready = !hold_full;
   assign line  = busy ? sh[0] : 1'b1;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < 7 || fmt.data8) frame[1+i] = hold_data[i];
      if (fmt.par_en) begin
         if (fmt.data8) frame[9] = par_bit(hold_data, 1'b1, fmt.par_even);
         else           frame[8] = par_bit(hold_data, 1'b0, fmt.par_even);
      end
      nbits = 4'd9 + {3'b0, fmt.data8} + {3'b0, fmt.par_en} + {3'b0, fmt.stop2};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
      end else begin
         if (start) hold_full <= 1'b0;
         if (load) begin
            hold_full <= 1'b1;
            hold_data <= load_data;
         end
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sh   <= '1;
         left <= '0;
         tcnt <= '0;
         busy <= 1'b0;
      end else if (start) begin
         sh   <= frame;
         left <= nbits;
         tcnt <= '0;
         busy <= 1'b1;
      end else if (busy && tick) begin
         tcnt <= tcnt + 4'd1;
         if (tcnt == 4'd15) begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end
      end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
   import sio_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  sio_fmt_t   fmt,
   input  logic       rx_en,
   input  logic       rxd,
   output logic       done,
   output logic [7:0] byte_out,
   output logic       perr,
   output logic       ferr
);
   rx_state_t          st;
   logic               prev;
   logic [3:0]         tcnt;
   logic [3:0]         bidx;
   logic [SAMP_W-1:0]  shr;
   logic [3:0]         last;
   logic               par_rx;

   assign last   = 4'd7 + {3'b0, fmt.data8} + {3'b0, fmt.par_en};
   assign par_rx = fmt.data8 ? shr[8] : shr[7];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st       <= RX_IDLE;
         prev     <= 1'b1;
         tcnt     <= '0;
         bidx     <= '0;
         shr      <= '0;
         done     <= 1'b0;
         byte_out <= '0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
      end else begin
         done <= 1'b0;
         prev <= rxd;
         if (!rx_en) st <= RX_IDLE;
         else begin
            case (st)
               RX_IDLE:
                  if (prev && !rxd) begin
                     st   <= RX_START;
                     tcnt <= '0;
                  end
               RX_START:
                  if (tick) begin
                     if (tcnt == 4'd7) begin
                        if (!rxd) begin
                           st   <= RX_BITS;
                           tcnt <= '0;
                           bidx <= '0;
                        end else st <= RX_IDLE;
                     end else tcnt <= tcnt + 4'd1;
                  end
               RX_BITS:
                  if (tick) begin
                     tcnt <= tcnt + 4'd1;
                     if (tcnt == 4'd15) begin
                        shr[bidx] <= rxd;
                        bidx      <= bidx + 4'd1;
                        if (bidx == last) begin
                           st       <= RX_IDLE;
                           done     <= 1'b1;
                           byte_out <= fmt.data8 ? shr[7:0] : {1'b0, shr[6:0]};
                           perr     <= fmt.par_en &&
                                       (par_rx != par_bit(shr[7:0], fmt.data8, fmt.par_even));
                           ferr     <= !rxd;
                        end
                     end
                  end
               default: st <= RX_IDLE;
            endcase
         end
      end
endmodule

// File: rtl/sio_window.sv
module sio_window
   import sio_pkg::*;
#(
   parameter int BASE_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n,
   input  logic       rd_n,
   input  logic       wr_n,
   input  logic [2:0] addr,
   inout  wire  [7:0] data,
   input  logic       rxd,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       dcd_n,
   input  logic       strap,
   output logic       txd,
   output logic       tape_out,
   output logic       irq_n
);
   localparam int CODE_W = 3;

   logic              rd_act, wr_act, rd_q, wr_q, wr_pulse, rd_end;
   logic [2:0]        rd_addr_q;
   logic [7:0]        rdata;
   sio_fmt_t          fmt;
   logic [CODE_W-1:0] baud;
   logic              tape_sel, rx_en, tx_en, tape_inv;
   logic              tick, rxd_s;
   logic              tx_ready, tx_busy, tx_line;
   logic              rx_done, rx_perr, rx_ferr;
   logic [7:0]        rx_byte, rx_hold;
   logic              rx_full, par_err, ovr_err, frm_err;

   assign rd_act   = !cs_n && !rd_n;
   assign wr_act   = !cs_n && !wr_n;
   assign wr_pulse = wr_act && !wr_q;
   assign rd_end   = rd_q && !rd_act;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rd_q      <= 1'b0;
         wr_q      <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_q <= rd_act;
         wr_q <= wr_act;
         if (rd_act) rd_addr_q <= addr;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         fmt      <= '0;
         baud     <= '0;
         tape_sel <= 1'b0;
         rx_en    <= 1'b0;
         tx_en    <= 1'b0;
         tape_inv <= 1'b0;
      end else if (wr_pulse) begin
         case (addr)
            OFF_STAT: fmt <= '{stop2: data[7], par_even: data[5], par_en: data[4], data8: data[2]};
            OFF_MODE: begin
               baud     <= data[CODE_W-1:0];
               tape_sel <= data[4];
               rx_en    <= data[6];
               tx_en    <= data[7];
            end
            OFF_AUX:  tape_inv <= data[4];
            default:  ;
         endcase
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         rx_full <= 1'b0;
         rx_hold <= '0;
         par_err <= 1'b0;
         ovr_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         if (rd_end && rd_addr_q == OFF_DATA) rx_full <= 1'b0;
         if (rd_end && rd_addr_q == OFF_STAT) begin
            par_err <= 1'b0;
            ovr_err <= 1'b0;
            frm_err <= 1'b0;
         end
         if (rx_done) begin
            if (rx_full) ovr_err <= 1'b1;
            else begin
               rx_full <= 1'b1;
               rx_hold <= rx_byte;
            end
            if (rx_perr) par_err <= 1'b1;
            if (rx_ferr) frm_err <= 1'b1;
         end
      end

   always_comb
      case (addr)
         OFF_DATA:  rdata = rx_hold;
         OFF_STAT:  rdata = {2'b00, frm_err, ovr_err, par_err, 1'b0, rx_full, tx_ready};
         OFF_MODE:  rdata = {tx_en, rx_en, 1'b0, tape_sel, 1'b0, baud};
         OFF_AUX:   rdata = {3'b000, tape_inv, 4'b0000};
         OFF_MODEM: rdata = {strap, 2'b00, ~dcd_n, ~dsr_n, ~cts_n, 2'b00};
         default:   rdata = 8'h00;
      endcase

   assign data     = rd_act ? rdata : 8'bzzzz_zzzz;
   assign txd      = tape_sel ? 1'b1 : tx_line;
   assign tape_out = (tape_sel ? tx_line : 1'b1) ^ tape_inv;
   assign irq_n    = !(rx_full || (tx_ready && tx_en));

   sio_baud #(.BASE_DIV(BASE_DIV), .CODE_W(CODE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .code(baud), .tick(tick));

   sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   sio_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .tx_en(tx_en),
      .load(wr_pulse && addr == OFF_DATA), .load_data(data),
      .ready(tx_ready), .busy(tx_busy), .line(tx_line));

   sio_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .rx_en(rx_en), .rxd(rxd_s),
      .done(rx_done), .byte_out(rx_byte), .perr(rx_perr), .ferr(rx_ferr));
endmodule

// File: rtl/sio_window_chk.sv
module sio_window_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       txd,
   input logic       irq_n,
   input logic       tape_sel,
   input logic       tx_en,
   input logic       tx_busy,
   input logic       rx_full,
   input logic       rx_done,
   input logic       ovr_err,
   input logic       rd_end,
   input logic [2:0] rd_addr_q
);
   assert_tape_mark_R12: assert property (@(posedge clk) disable iff (!rst_n)
      tape_sel |-> txd);

   assert_irq_rxfull_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> !irq_n);

   assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_full) |=> ovr_err);

   assert_rxflag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && rd_addr_q == sio_pkg::OFF_DATA && !rx_done) |=> !rx_full);

   assert_tx_start_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(tx_en));
endmodule

bind sio_window sio_window_chk u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .irq_n(irq_n), .tape_sel(tape_sel),
   .tx_en(tx_en), .tx_busy(tx_busy), .rx_full(rx_full), .rx_done(rx_done),
   .ovr_err(ovr_err), .rd_end(rd_end), .rd_addr_q(rd_addr_q));

// File: tb/sio_window_bench.sv
`timescale 1ns/1ps
module sio_window_bench;
   localparam int BASE = 2;
   localparam int BT   = 16 * BASE;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [2:0] addr = '0;
   logic       tb_drv = 1'b0;
   logic [7:0] tb_wdat = '0;
   wire  [7:0] bus_d;
   logic       rxd = 1'b1, cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, strap = 1'b0;
   logic       txd, tape_out, irq_n;
   int         n_chk = 0, n_fail = 0, txd_lows = 0;
   bit         finished = 0;

   assign bus_d = tb_drv ? tb_wdat : 8'bzzzz_zzzz;
   always #5 clk = ~clk;
   always @(negedge clk) if (txd === 1'b0) txd_lows++;

   sio_window #(.BASE_DIV(BASE), .SYNC_STAGES(2)) u_sio_window (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .data(bus_d), .rxd(rxd), .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n),
      .strap(strap), .txd(txd), .tape_out(tape_out), .irq_n(irq_n));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] v, input bit sel = 1);
      @(negedge clk);
      addr = a; tb_wdat = v; tb_drv = 1'b1; cs_n = !sel; wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      tb_drv = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      v = bus_d;
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [15:0] exp_frame(input logic [7:0] b, input bit d8,
                                             input bit pen, input bit even);
      logic [15:0] f;
      int nd;
      logic p;
      nd = d8 ? 8 : 7;
      f = '1; f[0] = 1'b0; p = 1'b0;
      for (int i = 0; i < nd; i++) begin
         f[1+i] = b[i];
         p = p ^ b[i];
      end
      if (pen) f[1+nd] = even ? p : ~p;
      return f;
   endfunction

   task automatic capture(input bit tape, input int n, output logic [15:0] got);
      int guard = 0;
      got = '1;
      while (((tape ? tape_out : txd) !== 1'b0) && guard < 20 * BT) begin
         @(negedge clk); guard++;
      end
      repeat (BT / 2) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         got[k] = tape ? tape_out : txd;
         repeat (BT) @(negedge clk);
      end
      repeat (BT) @(negedge clk);
   endtask

   task automatic rx_send(input logic [7:0] b, input bit d8, input bit pen, input bit even,
                          input bit flip, input bit stopv);
      logic [15:0] f;
      int nd;
      f = exp_frame(b, d8, pen, even);
      nd = d8 ? 8 : 7;
      if (pen && flip) f[1+nd] = ~f[1+nd];
      if (!stopv) f[1+nd+(pen ? 1 : 0)] = 1'b0;
      for (int k = 0; k < 2 + nd + (pen ? 1 : 0); k++) begin
         rxd = f[k];
         repeat (BT) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (BT) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      chk("R1 txd idle", txd, 1'b1);
      chk("R1 irq_n idle", irq_n, 1'b1);
      bus_rd(3'b011, v); chk("R1 status", v, 8'h01);
      bus_rd(3'b100, v); chk("R1 mode", v, 8'h00);
   endtask

   task automatic t_regs;
      logic [7:0] v;
      bus_wr(3'b100, 8'hFF); bus_rd(3'b100, v); chk("R2 mode readback", v, 8'hD7);
      bus_wr(3'b100, 8'h00);
      bus_wr(3'b101, 8'hFF); bus_rd(3'b101, v); chk("R2 aux readback", v, 8'h10);
      bus_wr(3'b101, 8'h00);
      bus_wr(3'b100, 8'h57, 0); bus_rd(3'b100, v); chk("R13 unselected write", v, 8'h00);
   endtask

   task automatic t_modem;
      logic [7:0] v;
      cts_n = 0; dsr_n = 1; dcd_n = 0; strap = 1;
      bus_rd(3'b110, v); chk("R3 modem pattern A", v, 8'h94);
      cts_n = 1; dsr_n = 0; dcd_n = 1; strap = 0;
      bus_rd(3'b110, v); chk("R3 modem pattern B", v, 8'h08);
      dsr_n = 1;
   endtask

   task automatic t_tx8n1;
      logic [15:0] got;
      int len;
      bus_wr(3'b011, 8'h04);
      bus_wr(3'b100, 8'h80);
      chk("R11 irq when tx ready and enabled", irq_n, 1'b0);
      bus_wr(3'b010, 8'hA5);
      capture(0, 10, got);
      chk("R4 frame 8N1 A5", got[9:0], exp_frame(8'hA5, 1, 0, 0) & 16'h03FF);
      bus_wr(3'b010, 8'h01);
      while (txd !== 1'b0) @(negedge clk);
      len = 0;
      while (txd === 1'b0 && len < 4 * BT) begin @(negedge clk); len++; end
      chk("R4 start bit length", (len >= BT - 2 && len <= BT + 2), 1'b1);
      repeat (10 * BT) @(negedge clk);
      bus_wr(3'b100, 8'h00);
      chk("R11 irq released", irq_n, 1'b1);
   endtask

   task automatic t_fmt;
      logic [15:0] got;
      bus_wr(3'b100, 8'h80);
      bus_wr(3'b011, 8'hB0);
      bus_wr(3'b010, 8'h53);
      capture(0, 11, got);
      chk("R5 7E2 frame", got[10:0], exp_frame(8'h53, 0, 1, 1) & 16'h07FF);
      bus_wr(3'b011, 8'h14);
      bus_wr(3'b010, 8'h07);
      capture(0, 11, got);
      chk("R5 8O1 frame", got[10:0], exp_frame(8'h07, 1, 1, 0) & 16'h07FF);
      bus_wr(3'b100, 8'h00);
   endtask

   task automatic t_txen;
      logic [7:0] v;
      logic [15:0] got;
      bus_wr(3'b011, 8'h04);
      txd_lows = 0;
      bus_wr(3'b010, 8'h3C);
      bus_rd(3'b011, v); chk("R6 held byte clears ready", v[0], 1'b0);
      repeat (3 * BT) @(negedge clk);
      chk("R6 txd stays mark while disabled", txd_lows, 0);
      bus_wr(3'b100, 8'h80);
      capture(0, 10, got);
      chk("R6 held byte sent", got[9:0], exp_frame(8'h3C, 1, 0, 0) & 16'h03FF);
      bus_wr(3'b100, 8'h00);
   endtask

   task automatic t_rx;
      logic [7:0] v;
      bus_wr(3'b011, 8'h04); bus_wr(3'b100, 8'h40);
      rx_send(8'hC3, 1, 0, 0, 0, 1);
      bus_rd(3'b011, v); chk("R7 received flag", v, 8'h03);
      chk("R11 irq on received byte", irq_n, 1'b0);
      bus_rd(3'b010, v); chk("R7 received byte", v, 8'hC3);
      bus_rd(3'b011, v); chk("R7 flag cleared by data read", v, 8'h01);
      chk("R11 irq released after read", irq_n, 1'b1);
      bus_wr(3'b011, 8'h00);
      rx_send(8'hFF, 0, 0, 0, 0, 1);
      bus_rd(3'b010, v); chk("R7 7-bit byte", v, 8'h7F);
   endtask

   task automatic t_rxerr;
      logic [7:0] v;
      bus_wr(3'b011, 8'h34);
      rx_send(8'h0F, 1, 1, 1, 1, 1);
      bus_rd(3'b011, v); chk("R8 parity error flag", v, 8'h0B);
      bus_rd(3'b011, v); chk("R8 parity error cleared", v, 8'h03);
      bus_rd(3'b010, v); chk("R8 byte with parity error", v, 8'h0F);
      bus_wr(3'b011, 8'h04);
      rx_send(8'h81, 1, 0, 0, 0, 0);
      bus_rd(3'b011, v); chk("R8 framing error flag", v, 8'h23);
      bus_rd(3'b010, v);
      bus_rd(3'b011, v); chk("R8 framing error cleared", v, 8'h01);
   endtask

   task automatic t_ovr;
      logic [7:0] v;
      rx_send(8'h11, 1, 0, 0, 0, 1);
      rx_send(8'h22, 1, 0, 0, 0, 1);
      bus_rd(3'b011, v); chk("R9 overrun flag", v, 8'h13);
      bus_rd(3'b010, v); chk("R9 first byte kept", v, 8'h11);
      bus_rd(3'b011, v); chk("R9 overrun cleared", v, 8'h01);
   endtask

   task automatic t_glitch;
      logic [7:0] v;
      rxd = 1'b0;
      repeat (BT / 8) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * BT) @(negedge clk);
      bus_rd(3'b011, v); chk("R10 glitch ignored", v, 8'h01);
      bus_wr(3'b100, 8'h00);
   endtask

   task automatic t_tape;
      logic [15:0] got;
      bus_wr(3'b011, 8'h04);
      bus_wr(3'b100, 8'h90);
      txd_lows = 0;
      bus_wr(3'b010, 8'h5A);
      capture(1, 10, got);
      chk("R12 frame on tape path", got[9:0], exp_frame(8'h5A, 1, 0, 0) & 16'h03FF);
      chk("R12 txd held at mark", txd_lows, 0);
      bus_wr(3'b101, 8'h10);
      chk("R12 inverted tape idle", tape_out, 1'b0);
      bus_wr(3'b101, 8'h00);
      chk("R12 tape idle mark", tape_out, 1'b1);
      bus_wr(3'b100, 8'h00);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_regs();
      t_modem();
      t_tx8n1();
      t_fmt();
      t_txen();
      t_rx();
      t_rxerr();
      t_ovr();
      t_glitch();
      t_tape();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule